// File: doc/BRIEF.md
# SD Card OCR Power-Up Sequencer

This block keeps the card-side Operation Conditions Register (OCR) during SD initialization and decides when the card reports itself as powered up. A command decoder upstream presents each ACMD41 as a one-cycle strobe, together with its 32-bit argument and a flag that says whether the card is in the idle state. The block returns the 32-bit OCR for the response and a one-cycle pulse that tells the card state machine to move toward the ready state.

An ACMD41 whose low 24 argument bits are zero is an enquiry. The first enquiry after reset starts a one-shot delay of `DELAY_CYCLES` clock cycles. This delay stands in for the nominal 0.5 ms power-up time, so the default is 50000 cycles at 100 MHz, and a bench can shorten it. The power-up bit is set when the delay expires. A non-enquiry request cancels any running delay and powers the card up at once.

Top module: `ocr_pwrup_seq`

## Requirements
- R1: While reset is asserted and right after its release, `ocr_o` reads 0x00FFFF00 (bits 23:8 set, power-up bit 31 clear), and `powered_o` and `card_ready_o` are 0.
- R2: Once set, OCR bit 31 stays set until the next reset. `powered_o` always equals `ocr_o[31]`, and `ocr_o[30:0]` never changes from 0x00FFFF00.
- R3: A request is an enquiry when `acmd_arg_i[23:0]` is zero and a non-enquiry otherwise. Bits 31:24 play no part in this.
- R4: A non-enquiry request in idle while bit 31 is clear sets bit 31 in the cycle after the strobe and cancels any pending delay.
- R5: An enquiry in idle while bit 31 is clear and no delay is pending starts the delay. Bit 31 reads 1 exactly `DELAY_CYCLES` cycles after the strobe edge.
- R6: An enquiry that arrives while a delay is pending does not restart it. Power-up still happens at the time set by the first enquiry.
- R7: A request with `card_idle_i` low does not start, stop or move the delay, does not set bit 31 and does not pulse `card_ready_o`.
- R8: `card_ready_o` is high for one cycle after each non-enquiry request taken in idle, and it is never raised by an enquiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acmd_valid_i | input | 1 | One-cycle ACMD41 strobe |
| acmd_arg_i | input | 32 | ACMD41 argument |
| card_idle_i | input | 1 | Card is in the idle state |
| ocr_o | output | 32 | Operation Conditions Register |
| powered_o | output | 1 | Power-up bit (OCR bit 31) |
| card_ready_o | output | 1 | One-cycle pulse to advance toward the ready state |

## Verification
A strobe taken at a clock edge shows its effect on `ocr_o` and `card_ready_o` after that same edge. A power-up caused by the delay shows after the edge that lies `DELAY_CYCLES` edges after the enquiry edge. The bench drives inputs on the falling edge and compares every output on the next falling edge, one rising edge later. A reference model advanced once per rising edge keeps an absolute due-edge number for the pending delay, so a wrongly restarted or cancelled delay shows up as a mismatch at a specific cycle.

// File: rtl/ocr_pkg.sv
package ocr_pkg;
  localparam logic [31:0] OCR_RESET_VAL  = 32'h00FF_FF00;
  localparam int unsigned PWR_BIT        = 31;
  localparam logic [31:0] ENQ_FIELD_MASK = 32'h00FF_FFFF;

  typedef enum logic [1:0] {
    ACT_NONE,
    ACT_ENQUIRY,
    ACT_POWER_NOW
  } acmd_act_e;
endpackage

// File: rtl/ocr_req_decode.sv
module ocr_req_decode
  import ocr_pkg::*;
(
  input  logic        valid_i,
  input  logic [31:0] arg_i,
  input  logic        idle_i,
  output acmd_act_e   act_o
);
  logic enquiry;
  assign enquiry = (arg_i & ENQ_FIELD_MASK) == 32'h0;

  always_comb begin
    act_o = ACT_NONE;
    if (valid_i && idle_i) act_o = enquiry ? ACT_ENQUIRY : ACT_POWER_NOW;
  end
endmodule

// File: rtl/ocr_delay_timer.sv
module ocr_delay_timer #(
  parameter int unsigned DELAY_CYCLES = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic cancel_i,
  output logic pending_o,
  output logic expire_o
);
  localparam int unsigned CNT_W = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(DELAY_CYCLES - 1);

  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cancel_i) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assign pending_o = busy_q;
  assign expire_o  = busy_q && (cnt_q == '0) && !cancel_i;

  AST_COUNT_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cnt_q != '0 && !cancel_i && !start_i |=> busy_q && cnt_q == $past(cnt_q) - CNT_W'(1)); // R5
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q); // R6
  AST_CANCEL_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cancel_i |=> !busy_q); // R4
endmodule

// File: rtl/ocr_status_reg.sv
module ocr_status_reg
  import ocr_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        set_i,
  input  logic        ready_req_i,
  output logic [31:0] ocr_o,
  output logic        pwr_o,
  output logic        ready_o
);
  logic pwr_q, ready_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_q   <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      if (set_i) pwr_q <= 1'b1;
      ready_q <= ready_req_i;
    end
  end

  always_comb begin
    ocr_o          = OCR_RESET_VAL;
    ocr_o[PWR_BIT] = pwr_q;
  end
  assign pwr_o   = pwr_q;
  assign ready_o = ready_q;

  AST_PWR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_q |=> pwr_q); // R2
  AST_SET_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pwr_q); // R5
  AST_READY_POWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |-> pwr_q); // R8
endmodule

// File: rtl/ocr_pwrup_seq.sv
module ocr_pwrup_seq
  import ocr_pkg::*;
#(
  parameter int unsigned DELAY_CYCLES = 50000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        acmd_valid_i,
  input  logic [31:0] acmd_arg_i,
  input  logic        card_idle_i,
  output logic [31:0] ocr_o,
  output logic        powered_o,
  output logic        card_ready_o
);
  acmd_act_e act;
  logic pending, expire, start, cancel, pwr;

  ocr_req_decode i_decode (
    .valid_i (acmd_valid_i),
    .arg_i   (acmd_arg_i),
    .idle_i  (card_idle_i),
    .act_o   (act)
  );

  // enquiry only arms an idle timer; non-enquiry overrides it
  assign start  = (act == ACT_ENQUIRY) && !pwr && !pending;
  assign cancel = (act == ACT_POWER_NOW) && !pwr;

  ocr_delay_timer #(.DELAY_CYCLES(DELAY_CYCLES)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .cancel_i  (cancel),
    .pending_o (pending),
    .expire_o  (expire)
  );

  ocr_status_reg i_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (cancel || expire),
    .ready_req_i (act == ACT_POWER_NOW),
    .ocr_o       (ocr_o),
    .pwr_o       (pwr),
    .ready_o     (card_ready_o)
  );

  assign powered_o = pwr;

  AST_POWER_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acmd_valid_i && card_idle_i && (acmd_arg_i & ENQ_FIELD_MASK) != 32'h0 |=> powered_o && card_ready_o && !pending); // R4
  AST_NONIDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acmd_valid_i && !card_idle_i && !powered_o && !pending |=> !powered_o && !card_ready_o && !pending); // R7
  AST_ENQ_NO_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acmd_valid_i && (acmd_arg_i & ENQ_FIELD_MASK) == 32'h0 |=> !card_ready_o); // R8
  AST_OCR_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ocr_o[30:0] == 31'h00FF_FF00 && ocr_o[31] == powered_o); // R2
endmodule

// File: tb/test_ocr_pwrup_seq.sv
module test_ocr_pwrup_seq;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned DLY = 12;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acmd_valid = 1'b0;
  logic [31:0] acmd_arg = '0;
  logic        card_idle = 1'b0;
  logic [31:0] ocr;
  logic        powered, card_ready;

  int checks = 0, errors = 0;
  int edge_n = 0;
  bit m_pwr = 0, m_pend = 0, m_ready = 0;
  int m_due = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ocr_pwrup_seq #(.DELAY_CYCLES(DLY)) i_ocr_pwrup_seq (
    .clk_i(clk), .rst_ni(rst_ni), .acmd_valid_i(acmd_valid), .acmd_arg_i(acmd_arg),
    .card_idle_i(card_idle), .ocr_o(ocr), .powered_o(powered), .card_ready_o(card_ready)
  );

  function automatic bit is_enq(logic [31:0] a);
    return a[23:0] == 24'h0;
  endfunction

  function automatic logic [31:0] exp_ocr(bit p);
    return {p, 31'h00FF_FF00};
  endfunction

  task automatic compare(string tag);
    checks++;
    if (ocr !== exp_ocr(m_pwr) || powered !== m_pwr || card_ready !== m_ready) begin
      errors++;
      $display("FAIL %s cyc %0d: ocr=%h pwr=%b rdy=%b exp ocr=%h pwr=%b rdy=%b",
               tag, edge_n, ocr, powered, card_ready, exp_ocr(m_pwr), m_pwr, m_ready);
    end
  endtask

  task automatic model_edge(bit v, logic [31:0] a, bit idle);
    bit exp_fire;
    edge_n++;
    exp_fire = m_pend && (edge_n == m_due);
    m_ready  = v && idle && !is_enq(a);
    if (v && idle && !m_pwr) begin
      if (!is_enq(a)) begin m_pwr = 1; m_pend = 0; end
      else if (!m_pend) begin m_pend = 1; m_due = edge_n + DLY; end
    end
    if (exp_fire) begin m_pwr = 1; m_pend = 0; end
  endtask

  // called at a negedge; compares at the next negedge
  task automatic cyc(bit v, logic [31:0] a, bit idle, string tag);
    acmd_valid = v; acmd_arg = a; card_idle = idle;
    @(posedge clk);
    model_edge(v, a, idle);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic quiet(int n, bit idle, string tag);
    for (int i = 0; i < n; i++) cyc(1'b0, 32'h0, idle, tag);
  endtask

  task automatic do_reset();
    acmd_valid = 0;
    rst_ni = 0;
    m_pwr = 0; m_pend = 0; m_ready = 0;
    @(negedge clk);
    compare("R1");
    rst_ni = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    compare("R1");
    rst_ni = 1;
    cyc(1'b0, 32'h0, 1'b1, "R1");

    // R5: enquiry timing
    cyc(1'b1, 32'h0000_0000, 1'b1, "R5");
    quiet(DLY + 3, 1'b1, "R5");

    // R6: second enquiry must not restart
    do_reset();
    cyc(1'b1, 32'h0, 1'b1, "R6");
    quiet(5, 1'b1, "R6");
    cyc(1'b1, 32'h0, 1'b1, "R6");
    quiet(DLY, 1'b1, "R6");

    // R4: non-enquiry cancels and powers now
    do_reset();
    cyc(1'b1, 32'h0, 1'b1, "R4");
    quiet(4, 1'b1, "R4");
    cyc(1'b1, 32'h0000_0001, 1'b1, "R4");
    quiet(DLY + 2, 1'b1, "R4");

    // R7: not idle has no effect, also while pending
    do_reset();
    cyc(1'b1, 32'h0, 1'b0, "R7");
    cyc(1'b1, 32'h00FF_8000, 1'b0, "R7");
    quiet(DLY + 2, 1'b1, "R7");
    cyc(1'b1, 32'h0, 1'b1, "R7");
    quiet(3, 1'b1, "R7");
    cyc(1'b1, 32'h0080_0000, 1'b0, "R7");
    quiet(DLY, 1'b0, "R7");

    // R3: high bits do not make a non-enquiry
    do_reset();
    cyc(1'b1, 32'hFF00_0000, 1'b1, "R3");
    quiet(DLY + 1, 1'b1, "R3");

    // R8: after power-up, enquiry gives no ready, non-enquiry does
    cyc(1'b1, 32'h0, 1'b1, "R8");
    cyc(1'b1, 32'h40FF_8000, 1'b1, "R8");
    cyc(1'b1, 32'h0000_0100, 1'b1, "R8");
    cyc(1'b0, 32'h0000_0100, 1'b1, "R8");

    // R2: sticky under arbitrary traffic
    quiet(10, 1'b0, "R2");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      bit v, idle;
      if (i % 300 == 0) do_reset();
      v    = ($urandom % 3) == 0;
      a    = $urandom;
      if ($urandom % 2) a = a & 32'hFF00_0000;
      idle = ($urandom % 4) != 0;
      cyc(v, a, idle, "R3");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule